// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a synchronous host port and an asynchronous extended-data-out DRAM that has a narrow data path and multiplexed addressing. Each host request carries one word address. The upper part of that address selects a row and the lower part selects a column. The controller opens the row with the row strobe, presents the column under the column strobe, and moves one data word per request. It drives the active-low strobes, the shared address pins, the write and output enables, and the direction control of the data pins.

After an access the row stays open. A later request to the same row runs as a short page cycle, and the row strobe does not toggle for it. The row is closed in three cases:

- a request arrives for a different row;
- the row-low window is about to exceed its limit;
- an external refresh owner withdraws the grant input.

Read data is captured at the end of the column precharge phase rather than at the column strobe's rising edge. This relies on the extended hold time of the memory's output. Every timing limit is a parameter counted in whole clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While rst_ni is low, all four strobes (ras_n_o, cas_n_o, we_n_o, oe_n_o) are high (inactive), dq_oe_o is 0 and rd_valid_o is 0.
- R2: The row is the upper ROW_W bits of req_addr_i and the column is the lower COL_W bits. Both are zero-extended onto dram_addr_o. The row is on dram_addr_o when ras_n_o falls, and the column of the same request is on it when cas_n_o falls.
- R3: After a row activation, dram_addr_o keeps the row for T_RAH cycles. The first fall of cas_n_o follows the fall of ras_n_o by exactly T_RCD cycles.
- R4: ras_n_o stays high for at least T_RP cycles between two falls.
- R5: A request to the open row is served with no rise of ras_n_o. In every column cycle cas_n_o stays low for exactly T_CAS cycles, and it stays high for at least T_CP cycles between columns. cas_n_o is low only while ras_n_o is low.
- R6: A request to a row other than the open one raises ras_n_o, waits out the precharge time, and then activates the new row.
- R7: ras_n_o never stays low for more than T_RAS_MAX cycles. When the limit approaches, the row is closed even while requests to it keep arriving.
- R8: A write drives we_n_o low, dq_oe_o high and the write data on dq_o no later than the fall of cas_n_o, with oe_n_o high. A read keeps we_n_o high and dq_oe_o low, and holds oe_n_o low while cas_n_o is low.
- R9: Each read returns its word on rd_data_o with a one-cycle rd_valid_o pulse. The pulse comes T_CP cycles after cas_n_o rises, while cas_n_o is still high. Read words return in request order.
- R10: While gnt_i is low, req_ready_o is low and no row is activated. An open row is closed once its current column cycle ends.
- R11: A request is taken only in a cycle where req_valid_i and req_ready_o are both 1, and each taken request produces exactly one fall of cas_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Access grant; low while another agent (refresh) owns the memory |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller accepts the request this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata_i | input | DW | Write data |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | DW | Read data |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_o | output | DW | Data toward the memory |
| dq_oe_o | output | 1 | 1 = controller drives the data pins |
| dq_i | input | DW | Data from the memory |

## Verification
The hardest situation to reach from the ports is a forced row close by the row-low limit in the middle of a stream of same-row hits. A second hard case is a grant withdrawal that lands while a row is open. The bench shortens the row-low limit to a few dozen cycles and issues a burst of sixteen same-row writes, which must split across several activations. It also drops the grant right after a read has left its row open. A behavioural memory model keeps read data valid after the column strobe rises and releases it only at the next column strobe or when both strobes are high. This means a capture taken too late or too early shows up as a data mismatch.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_CAS,
    ST_CP,
    ST_OPEN
  } seq_st_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/edo_dcnt.sv
// Precharge down counter: loaded on row close, done when it reaches zero.
module edo_dcnt #(
  parameter int unsigned LOAD = 3,
  localparam int unsigned W = $clog2(LOAD + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= W'(LOAD);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/edo_ras_win.sv
// Counts cycles of row-low time; flags when no further column may start.
module edo_ras_win #(
  parameter int unsigned T_MAX  = 10000,
  parameter int unsigned MARGIN = 5,
  localparam int unsigned CW  = $clog2(T_MAX + 1),
  localparam int unsigned LIM = T_MAX - MARGIN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic row_open_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!row_open_i)           cnt_q <= '0;
    else if (cnt_q != CW'(T_MAX))   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (cnt_q >= CW'(LIM));
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W = 10,
  parameter int unsigned COL_W = 10,
  parameter int unsigned DW    = 4,
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RAH = 1,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_CP  = 1,
  localparam int unsigned AW   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_we_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic             prech_done_i,
  input  logic             ras_expire_i,
  output logic             close_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic [AW-1:0]    dram_addr_o,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o,
  input  logic [DW-1:0]    dq_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o
);
  localparam int unsigned PMAX = max3(T_RCD, T_CAS, T_CP);
  localparam int unsigned PW   = $clog2(PMAX + 1);
  localparam logic [PW-1:0] RAH_END = PW'(T_RAH - 1);
  localparam logic [PW-1:0] RCD_END = PW'(T_RCD - 1);
  localparam logic [PW-1:0] CAS_END = PW'(T_CAS - 1);
  localparam logic [PW-1:0] CP_END  = PW'(T_CP - 1);

  seq_st_e          st_q;
  logic [PW-1:0]    ph_q;
  logic [ROW_W-1:0] open_row_q;
  logic [COL_W-1:0] lat_col_q;
  logic             lat_we_q;
  logic [DW-1:0]    lat_wd_q;
  logic             rd_pend_q;

  logic hit, accept, close_cond;

  always_comb begin
    hit         = (req_row_i == open_row_q);
    req_ready_o = ((st_q == ST_IDLE) && gnt_i && prech_done_i) ||
                  ((st_q == ST_OPEN) && gnt_i && !ras_expire_i && hit);
    accept      = req_valid_i && req_ready_o;
    close_cond  = !gnt_i || ras_expire_i || (req_valid_i && !hit);
    close_o     = (st_q == ST_OPEN) && !accept && close_cond;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ph_q        <= '0;
      open_row_q  <= '0;
      lat_col_q   <= '0;
      lat_we_q    <= 1'b0;
      lat_wd_q    <= '0;
      rd_pend_q   <= 1'b0;
      ras_n_o     <= 1'b1;
      cas_n_o     <= 1'b1;
      we_n_o      <= 1'b1;
      oe_n_o      <= 1'b1;
      dram_addr_o <= '0;
      dq_o        <= '0;
      dq_oe_o     <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            ras_n_o     <= 1'b0;
            dram_addr_o <= AW'(req_row_i);
            open_row_q  <= req_row_i;
            lat_col_q   <= req_col_i;
            lat_we_q    <= req_we_i;
            lat_wd_q    <= req_wdata_i;
            ph_q        <= '0;
            st_q        <= ST_ACT;
          end
        end
        ST_ACT: begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == RAH_END) begin
            // column and early-write setup ahead of the column strobe
            dram_addr_o <= AW'(lat_col_q);
            we_n_o      <= !lat_we_q;
            oe_n_o      <= lat_we_q;
            dq_oe_o     <= lat_we_q;
            dq_o        <= lat_wd_q;
          end
          if (ph_q == RCD_END) begin
            cas_n_o   <= 1'b0;
            rd_pend_q <= !lat_we_q;
            ph_q      <= '0;
            st_q      <= ST_CAS;
          end
        end
        ST_CAS: begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == CAS_END) begin
            cas_n_o <= 1'b1;
            we_n_o  <= 1'b1;
            dq_oe_o <= 1'b0;
            ph_q    <= '0;
            st_q    <= ST_CP;
          end
        end
        ST_CP: begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == CP_END) begin
            // extended data out: word still valid after the column strobe rose
            if (rd_pend_q) begin
              rd_valid_o <= 1'b1;
              rd_data_o  <= dq_i;
            end
            rd_pend_q <= 1'b0;
            oe_n_o    <= 1'b1;
            ph_q      <= '0;
            st_q      <= ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (accept) begin
            dram_addr_o <= AW'(req_col_i);
            cas_n_o     <= 1'b0;
            we_n_o      <= !req_we_i;
            oe_n_o      <= req_we_i;
            dq_oe_o     <= req_we_i;
            dq_o        <= req_wdata_i;
            rd_pend_q   <= !req_we_i;
            ph_q        <= '0;
            st_q        <= ST_CAS;
          end else if (close_cond) begin
            ras_n_o <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned DW        = 4,
  parameter int unsigned T_RP      = 4,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RAH     = 1,
  parameter int unsigned T_CAS     = 2,
  parameter int unsigned T_CP      = 1,
  parameter int unsigned T_RAS_MAX = 10000,
  localparam int unsigned AW = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int unsigned RW = ROW_W + COL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gnt_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [RW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          ras_n_o,
  output logic          cas_n_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  output logic [AW-1:0] dram_addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] dq_i
);
  // worst case from the last accepted column to the row close decision
  localparam int unsigned WIN_MARGIN = T_CAS + T_CP + 2;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             prech_done, ras_expire, close_row;

  assign req_row = req_addr_i[RW-1:COL_W];
  assign req_col = req_addr_i[COL_W-1:0];

  edo_dcnt #(.LOAD(T_RP - 1)) u_prech (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (close_row),
    .done_o (prech_done)
  );

  edo_ras_win #(.T_MAX(T_RAS_MAX), .MARGIN(WIN_MARGIN)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_open_i (!ras_n_o),
    .expire_o   (ras_expire)
  );

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW),
    .T_RCD(T_RCD), .T_RAH(T_RAH), .T_CAS(T_CAS), .T_CP(T_CP)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gnt_i        (gnt_i),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_we_i     (req_we_i),
    .req_row_i    (req_row),
    .req_col_i    (req_col),
    .req_wdata_i  (req_wdata_i),
    .prech_done_i (prech_done),
    .ras_expire_i (ras_expire),
    .close_o      (close_row),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n_o),
    .we_n_o       (we_n_o),
    .oe_n_o       (oe_n_o),
    .dram_addr_o  (dram_addr_o),
    .dq_o         (dq_o),
    .dq_oe_o      (dq_oe_o),
    .dq_i         (dq_i),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o)
  );
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int unsigned T_RP      = 4,
  parameter int unsigned T_RAS_MAX = 10000,
  localparam int unsigned HW = $clog2(T_RP + 1),
  localparam int unsigned LW = $clog2(T_RAS_MAX + 1)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic gnt_i,
  input logic req_ready_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o,
  input logic oe_n_o,
  input logic dq_oe_o,
  input logic rd_valid_o
);
  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= HW'(T_RP);
      lo_cnt <= '0;
    end else begin
      if (!ras_n_o)                   hi_cnt <= '0;
      else if (hi_cnt != HW'(T_RP))   hi_cnt <= hi_cnt + 1'b1;
      if (ras_n_o)                    lo_cnt <= '0;
      else if (lo_cnt != LW'(T_RAS_MAX)) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  a_r4_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> hi_cnt >= HW'(T_RP));

  a_r7_ras_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> lo_cnt < LW'(T_RAS_MAX));

  a_r5_cas_in_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> !ras_n_o);

  a_r8_write_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_o && !we_n_o) |-> (dq_oe_o && oe_n_o));

  a_r8_read_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_o && we_n_o) |-> (!dq_oe_o && !oe_n_o));

  a_r10_act_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(gnt_i));

  a_r10_ready_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> gnt_i);

  a_r9_capture_cas_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> cas_n_o);
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(.T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gnt_i       (gnt_i),
  .req_ready_o (req_ready_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .oe_n_o      (oe_n_o),
  .dq_oe_o     (dq_oe_o),
  .rd_valid_o  (rd_valid_o)
);

// File: tb/edo_dram_ctrl_tb_top.sv
module edo_dram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 3, COL_W = 3, DW = 4;
  localparam int T_RP = 3, T_RCD = 3, T_RAH = 1, T_CAS = 2, T_CP = 2, T_RAS_MAX = 30;
  localparam int NW = 1 << (ROW_W + COL_W);

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rd_data, dq_o, dq_in;
  logic [2:0] dram_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  edo_dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_RAH(T_RAH), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS_MAX(T_RAS_MAX)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .oe_n_o(oe_n),
    .dram_addr_o(dram_addr), .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_in)
  );

  int checks = 0, errors = 0, cyc = 0;
  int act_cnt = 0, cas_falls = 0, accepts = 0;
  int last_row = 0, last_col = 0;
  bit last_we = 0;
  logic [DW-1:0] last_wd = '0;
  logic [DW-1:0] ref_mem [NW];
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] exp_q [$];

  // memory model state
  int row_l = 0, since = 0, ras_hi = 1000, ras_lo = 0, cas_hi = 1000, cas_lo = 0;
  bit prev_ras = 1, prev_cas = 1, first_col = 0, out_v = 0;
  logic [DW-1:0] out_d = '0;

  assign dq_in = (out_v && !oe_n) ? out_d : 'x;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i] = '0;
      ref_mem[i] = '0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit rf, rr, cf, cr;
      rf = prev_ras && !ras_n;
      rr = !prev_ras && ras_n;
      cf = prev_cas && !cas_n;
      cr = !prev_cas && cas_n;
      if (rf) begin
        chk(ras_hi >= T_RP, "R4 precharge", ras_hi, T_RP);
        act_cnt++;
        row_l = int'(dram_addr);
        chk(row_l == last_row, "R2 row on RAS fall", row_l, last_row);
        first_col = 1;
        since = 0;
      end else if (!ras_n) since++;
      if (!ras_n && since < T_RAH)
        chk(int'(dram_addr) == last_row, "R3 row hold", int'(dram_addr), last_row);
      if (rr) chk(ras_lo <= T_RAS_MAX, "R7 row-low window", ras_lo, T_RAS_MAX);
      if (cf) begin
        cas_falls++;
        chk(!ras_n, "R5 CAS inside row", int'(ras_n), 0);
        if (first_col) chk(since == T_RCD, "R3 RAS-to-CAS", since, T_RCD);
        else           chk(cas_hi >= T_CP, "R5 CAS precharge", cas_hi, T_CP);
        first_col = 0;
        chk(int'(dram_addr) == last_col, "R2 column on CAS fall", int'(dram_addr), last_col);
        if (last_we) begin
          chk(!we_n && dq_oe && oe_n && dq_o == last_wd, "R8 early write", int'(dq_o), int'(last_wd));
          mem[row_l * (1 << COL_W) + int'(dram_addr)] = dq_o;
          out_v = 0;
        end else begin
          chk(we_n && !dq_oe && !oe_n, "R8 read enables", int'({we_n, dq_oe, oe_n}), 3'b100);
          out_d = mem[row_l * (1 << COL_W) + int'(dram_addr)];
          out_v = 1;
        end
      end
      if (cr) chk(cas_lo == T_CAS, "R5 CAS low width", cas_lo, T_CAS);
      ras_hi = ras_n ? ras_hi + 1 : 0;
      ras_lo = ras_n ? 0 : ras_lo + 1;
      cas_hi = cas_n ? cas_hi + 1 : 0;
      cas_lo = cas_n ? 0 : cas_lo + 1;
      if (ras_n && cas_n) out_v = 0;
      if (rd_valid) begin
        chk(cas_hi == T_CP + 1, "R9 capture point", cas_hi, T_CP + 1);
        if (exp_q.size() == 0) chk(0, "R9 unexpected read data", int'(rd_data), -1);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rd_data === e, "R9 read data", int'(rd_data), int'(e));
        end
      end
      if (dq_oe && out_v && !oe_n) chk(0, "R8 bus contention", 1, 0);
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic issue(input bit we, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_we = we;
    req_addr = (ROW_W + COL_W)'(a);
    req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    accepts++;
    last_row = a >> COL_W;
    last_col = a & ((1 << COL_W) - 1);
    last_we = we;
    last_wd = d;
    if (we) ref_mem[a] = d;
    else exp_q.push_back(ref_mem[a]);
    #1 req_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0;
    int unsigned seed;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset", int'({ras_n, cas_n, we_n, oe_n}), 15);
    chk(!dq_oe && !rd_valid, "R1 enables in reset", int'({dq_oe, rd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && !dq_oe, "R1 idle after reset", int'({ras_n, cas_n, dq_oe}), 6);

    // full write then row-major read: page hits inside each row
    for (int a = 0; a < NW; a++) issue(1, a, DW'(a * 5 + 3));
    for (int a = 0; a < NW; a++) issue(0, a, '0);

    // column-major read: every access is a row miss
    repeat (2) @(negedge clk);
    a0 = act_cnt;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) issue(0, r * 8 + c, '0);
    repeat (2) @(negedge clk);
    chk(act_cnt - a0 == 64, "R6 miss activations", act_cnt - a0, 64);

    // short page run: one activation only
    issue(0, 8, '0);
    repeat (2) @(negedge clk);
    a0 = act_cnt;
    issue(0, 17, '0);
    issue(0, 20, '0);
    issue(1, 22, 4'hA);
    repeat (2) @(negedge clk);
    chk(act_cnt - a0 == 1, "R5 page hits", act_cnt - a0, 1);

    // long same-row burst must be split by the row-low window
    a0 = act_cnt;
    for (int i = 0; i < 16; i++) issue(1, 5 * 8 + (i % 8), DW'(i * 7 + 1));
    repeat (2) @(negedge clk);
    chk(act_cnt - a0 >= 2, "R7 forced close", act_cnt - a0, 2);

    // grant withdrawn with a row open
    issue(0, 3 * 8 + 1, '0);
    repeat (2) @(negedge clk);
    gnt = 1'b0;
    repeat (T_CAS + T_CP + 4) @(negedge clk);
    chk(ras_n, "R10 row closed without grant", int'(ras_n), 1);
    req_valid = 1'b1;
    req_we = 1'b0;
    req_addr = 6'd9;
    a0 = act_cnt;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      #1 chk(!req_ready && ras_n, "R10 no access without grant", int'({req_ready, ras_n}), 1);
    end
    chk(act_cnt == a0, "R11 no accept without ready", act_cnt - a0, 0);
    req_valid = 1'b0;
    gnt = 1'b1;

    // mixed pseudo-random traffic
    seed = 32'd12345;
    for (int i = 0; i < 200; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      issue(seed[20], int'(seed[13:8]), seed[7:4]);
    end

    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
    chk(cas_falls == accepts, "R11 one column per request", cas_falls, accepts);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule